// File: doc/BRIEF.md
# Multi-Channel Frequency Counter with Serial Text Report

This block measures several unrelated input clocks against one reference clock and reports each reading as a line of ASCII text on a serial transmit pin. A plain terminal shows the readings, so the board can be checked without any host software. Each measured clock drives its own Gray-coded counter in its own domain. The reference domain samples every counter through a two-flop synchronizer. A gate timer of `GATE_CYCLES` reference cycles sets the measurement window, and the change in a counter across one gate gives the edge count for that channel.

A formatter steps through the channels in turn. For each line it takes a snapshot of the channel's latest count and clamps it to the largest value the digits can show. A sequential shift-and-add-3 converter turns the snapshot into BCD, and the formatter then sends the line one character at a time through an 8N1 transmitter. With the default 125 MHz reference and a gate of 12,500,000 cycles (0.1 s), the count read as `DDD.DDDDD` is the frequency in MHz, with a 10 Hz step. The default bit divider gives roughly 9600 baud.

Top module: `freq_report`

## Requirements
- R1: `uart_tx` is high during reset and whenever no character is being sent. Each character is one low start bit, then 8 data bits least significant bit first, then one high stop bit. Every bit lasts `BAUD_DIV` reference cycles.
- R2: Each line has this exact form: the text `Channel `, the channel number as one ASCII digit, `:`, two spaces, `INT_DIGITS` decimal digits, `.`, `FRAC_DIGITS` decimal digits, a space, `MHz`, then carriage return (13) and line feed (10).
- R3: Lines run through channels 0, 1, …, `NCH-1` and then start again at 0. They repeat forever with no request from outside.
- R4: The digits of a line, read as one decimal integer with leading zeros kept, equal the number of rising edges of that channel's clock during one gate of `GATE_CYCLES` reference cycles. Each channel is counted on its own.
- R5: If a channel's clock stops, that channel reports all zeros from the second full gate after the stop.
- R6: A count larger than 10^(`INT_DIGITS`+`FRAC_DIGITS`)−1 is printed as all nines.
- R7: The digits of a line come from one snapshot taken before the line's first character. They do not change while the line is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; times the gate and the serial bits |
| rst | input | 1 | Synchronous active-high reset in the `clk` domain |
| meas_clk | input | NCH | Clocks to be measured, one per channel, each asynchronous |
| uart_tx | output | 1 | Serial text output, 8N1, idle high |

## Verification
The bench drives four measured clocks whose periods divide the gate exactly, at fixed phase offsets from the reference. Each reading is therefore exact. A design that adds or drops an edge at the window boundary, or that adds the synchronizer delay twice, prints a count that is off by one.

After one clock is stopped, the bench expects that channel to show zeros while the other channels keep their values. A design that holds the last difference, or that mixes up channels, fails here.

A second instance has only two digits, so real counts exceed its range. The bench expects `9.9` from it; wrapping or truncating the count gives other digits.

The bench decodes every character on the serial line at its bit centres. A wrong bit order or a short stop bit therefore breaks the decoded text, and the channel digits must also follow each other in order.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;
  typedef enum logic [1:0] {
    FMT_LATCH,
    FMT_CONV,
    FMT_EMIT,
    FMT_WAIT
  } fmt_state_e;

  localparam logic [7:0] ASC_ZERO = 8'h30;
  localparam logic [7:0] ASC_SP   = 8'h20;
  localparam logic [7:0] ASC_CR   = 8'h0D;
  localparam logic [7:0] ASC_LF   = 8'h0A;
endpackage

// File: rtl/fc_chan_counter.sv
`timescale 1ns/1ps
module fc_chan_counter #(
  parameter int CNT_W = 28
) (
  input  logic             meas_clk,
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);
  // reset brought into the measured domain
  logic [1:0]       rst_m;
  logic [CNT_W-1:0] bin_m, bin_nxt, gray_m;
  logic [CNT_W-1:0] gray_s1, gray_s2, bin_s;

  always_ff @(posedge meas_clk) rst_m <= {rst_m[0], rst};

  assign bin_nxt = bin_m + 1'b1;

  always_ff @(posedge meas_clk) begin
    if (rst_m[1]) begin
      bin_m  <= '0;
      gray_m <= '0;
    end else begin
      bin_m  <= bin_nxt;
      gray_m <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  // two-flop crossing of the Gray value
  always_ff @(posedge clk) begin
    gray_s1 <= gray_m;
    gray_s2 <= gray_s1;
  end

  always_comb begin
    for (int i = 0; i < CNT_W; i++) bin_s[i] = ^(gray_s2 >> i);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= bin_s;
  end
endmodule

// File: rtl/fc_gate.sv
`timescale 1ns/1ps
module fc_gate #(
  parameter int NCH         = 4,
  parameter int CNT_W       = 28,
  parameter int GATE_CYCLES = 12_500_000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NCH-1:0][CNT_W-1:0]  cnt_i,
  output logic [NCH-1:0][CNT_W-1:0]  res_o
);
  localparam int GW = $clog2(GATE_CYCLES);

  logic [GW-1:0]              tmr_q;
  logic                       primed_q;
  logic                       tick;
  logic [NCH-1:0][CNT_W-1:0]  prev_q;

  assign tick = (tmr_q == GW'(GATE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q    <= '0;
      primed_q <= 1'b0;
      prev_q   <= '0;
      res_o    <= '0;
    end else begin
      tmr_q <= tick ? '0 : tmr_q + 1'b1;
      if (tick) begin
        primed_q <= 1'b1;
        for (int c = 0; c < NCH; c++) begin
          prev_q[c] <= cnt_i[c];
          if (primed_q) res_o[c] <= cnt_i[c] - prev_q[c];
        end
      end
    end
  end
endmodule

// File: rtl/fc_bin2bcd.sv
`timescale 1ns/1ps
module fc_bin2bcd #(
  parameter int BIN_W = 28,
  parameter int NDIG  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [BIN_W-1:0]  bin_i,
  output logic              done_o,
  output logic [NDIG*4-1:0] bcd_o
);
  localparam int BCD_W = NDIG * 4;
  localparam int CW    = $clog2(BIN_W + 1);

  logic [BIN_W-1:0] sh_q;
  logic [CW-1:0]    left_q;
  logic             busy_q;
  logic [BCD_W-1:0] adj;

  always_comb begin
    adj = bcd_o;
    for (int d = 0; d < NDIG; d++)
      if (adj[4*d +: 4] >= 4'd5) adj[4*d +: 4] = adj[4*d +: 4] + 4'd3;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcd_o  <= '0;
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else if (start_i) begin
      bcd_o  <= '0;
      sh_q   <= bin_i;
      left_q <= CW'(BIN_W);
      busy_q <= 1'b1;
      done_o <= 1'b0;
    end else if (busy_q) begin
      {bcd_o, sh_q} <= {adj[BCD_W-2:0], sh_q, 1'b0};
      left_q        <= left_q - 1'b1;
      if (left_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_o <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fc_uart_tx.sv
`timescale 1ns/1ps
module fc_uart_tx #(
  parameter int DIV = 13021
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       tx_o
);
  localparam int DW = $clog2(DIV + 1);

  logic [DW-1:0] div_q;
  logic [3:0]    nbit_q;
  logic [8:0]    frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o  <= 1'b0;
      tx_o    <= 1'b1;
      div_q   <= '0;
      nbit_q  <= '0;
      frame_q <= '1;
    end else if (!busy_o) begin
      if (load_i) begin
        frame_q <= {1'b1, data_i};
        tx_o    <= 1'b0;
        busy_o  <= 1'b1;
        div_q   <= DW'(DIV - 1);
        nbit_q  <= '0;
      end
    end else if (div_q != '0) begin
      div_q <= div_q - 1'b1;
    end else begin
      div_q <= DW'(DIV - 1);
      if (nbit_q == 4'd9) begin
        busy_o <= 1'b0;
      end else begin
        tx_o    <= frame_q[0];
        frame_q <= {1'b1, frame_q[8:1]};
        nbit_q  <= nbit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/freq_report.sv
`timescale 1ns/1ps
module freq_report
  import fc_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int CNT_W       = 28,
  parameter int GATE_CYCLES = 12_500_000,
  parameter int BAUD_DIV    = 13021,
  parameter int INT_DIGITS  = 3,
  parameter int FRAC_DIGITS = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] meas_clk,
  output logic           uart_tx
);
  localparam int NDIG     = INT_DIGITS + FRAC_DIGITS;
  localparam int BCD_W    = NDIG * 4;
  localparam int LINE_LEN = 19 + NDIG;
  localparam int POS_W    = $clog2(LINE_LEN + 1);
  localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int P_DIG    = 12;
  localparam int P_DOT    = P_DIG + INT_DIGITS;
  localparam int P_UNIT   = P_DOT + 1 + FRAC_DIGITS;
  localparam int P_CR     = P_UNIT + 4;
  localparam logic [CNT_W-1:0] MAX_VAL = CNT_W'(10**NDIG - 1);

  logic [NCH-1:0][CNT_W-1:0] cnt_ref, result;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    fc_chan_counter #(.CNT_W(CNT_W)) u_cnt (
      .meas_clk(meas_clk[c]), .clk(clk), .rst(rst), .cnt_o(cnt_ref[c])
    );
  end

  fc_gate #(.NCH(NCH), .CNT_W(CNT_W), .GATE_CYCLES(GATE_CYCLES)) u_gate (
    .clk(clk), .rst(rst), .cnt_i(cnt_ref), .res_o(result)
  );

  fmt_state_e       state;
  logic [CH_W-1:0]  chan_sel;
  logic [POS_W-1:0] pos;
  logic [CNT_W-1:0] snap_cnt;
  logic [BCD_W-1:0] snap_bcd, conv_bcd;
  logic             conv_start, conv_done;
  logic             tx_load, tx_busy;
  logic [7:0]       tx_data, ch_byte;
  logic             in_line, line_done, char_done;

  fc_bin2bcd #(.BIN_W(CNT_W), .NDIG(NDIG)) u_bcd (
    .clk(clk), .rst(rst), .start_i(conv_start), .bin_i(snap_cnt),
    .done_o(conv_done), .bcd_o(conv_bcd)
  );

  fc_uart_tx #(.DIV(BAUD_DIV)) u_tx (
    .clk(clk), .rst(rst), .load_i(tx_load), .data_i(tx_data),
    .busy_o(tx_busy), .tx_o(uart_tx)
  );

  assign in_line   = (state == FMT_EMIT) || (state == FMT_WAIT);
  assign char_done = (state == FMT_WAIT) && !tx_busy && !tx_load;
  assign line_done = char_done && (pos == POS_W'(LINE_LEN - 1));

  // character at the current line position
  always_comb begin
    int p;
    int d;
    p = int'(pos);
    d = 0;
    ch_byte = ASC_SP;
    if (p < 8) begin
      case (p)
        0: ch_byte = "C";
        1: ch_byte = "h";
        2: ch_byte = "a";
        3: ch_byte = "n";
        4: ch_byte = "n";
        5: ch_byte = "e";
        6: ch_byte = "l";
        default: ch_byte = ASC_SP;
      endcase
    end else if (p == 8) begin
      ch_byte = ASC_ZERO + 8'(chan_sel);
    end else if (p == 9) begin
      ch_byte = ":";
    end else if (p < P_DIG) begin
      ch_byte = ASC_SP;
    end else if (p < P_DOT) begin
      d = NDIG - 1 - (p - P_DIG);
      ch_byte = ASC_ZERO + {4'h0, snap_bcd[4*d +: 4]};
    end else if (p == P_DOT) begin
      ch_byte = ".";
    end else if (p < P_UNIT) begin
      d = P_UNIT - 1 - p;
      ch_byte = ASC_ZERO + {4'h0, snap_bcd[4*d +: 4]};
    end else if (p == P_UNIT) begin
      ch_byte = ASC_SP;
    end else if (p == P_UNIT + 1) begin
      ch_byte = "M";
    end else if (p == P_UNIT + 2) begin
      ch_byte = "H";
    end else if (p == P_UNIT + 3) begin
      ch_byte = "z";
    end else if (p == P_CR) begin
      ch_byte = ASC_CR;
    end else begin
      ch_byte = ASC_LF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= FMT_LATCH;
      chan_sel   <= '0;
      pos        <= '0;
      snap_cnt   <= '0;
      snap_bcd   <= '0;
      conv_start <= 1'b0;
      tx_load    <= 1'b0;
      tx_data    <= 8'h00;
    end else begin
      case (state)
        FMT_LATCH: begin
          snap_cnt   <= (result[chan_sel] > MAX_VAL) ? MAX_VAL : result[chan_sel];
          conv_start <= 1'b1;
          state      <= FMT_CONV;
        end
        FMT_CONV: begin
          conv_start <= 1'b0;
          if (conv_done) begin
            snap_bcd <= conv_bcd;
            pos      <= '0;
            state    <= FMT_EMIT;
          end
        end
        FMT_EMIT: begin
          if (!tx_busy) begin
            tx_load <= 1'b1;
            tx_data <= ch_byte;
            state   <= FMT_WAIT;
          end
        end
        default: begin
          tx_load <= 1'b0;
          if (line_done) begin
            pos      <= '0;
            chan_sel <= (chan_sel == CH_W'(NCH - 1)) ? '0 : chan_sel + 1'b1;
            state    <= FMT_LATCH;
          end else if (char_done) begin
            pos   <= pos + 1'b1;
            state <= FMT_EMIT;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fc_report_chk.sv
`timescale 1ns/1ps
module fc_report_chk #(
  parameter int NCH     = 4,
  parameter int CNT_W   = 28,
  parameter int BCD_W   = 32,
  parameter int MAX_VAL = 99_999_999
) (
  input logic             clk,
  input logic             rst,
  input logic             uart_tx,
  input logic             tx_busy,
  input logic             in_line,
  input logic [BCD_W-1:0] snap_bcd,
  input logic [$clog2(NCH > 1 ? NCH : 2)-1:0] chan_sel,
  input logic             line_done,
  input logic             conv_start,
  input logic [CNT_W-1:0] snap_cnt
);
  function automatic logic digits_ok(input logic [BCD_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < BCD_W / 4; d++)
      if (v[4*d +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R1
  tx_reset_high_chk: assert property (@(posedge clk) rst |=> uart_tx);

  // R1
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> uart_tx);

  // R3
  chan_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_sel) |-> $past(line_done));

  // R6
  sat_limit_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (snap_cnt <= CNT_W'(MAX_VAL)));

  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_line && $past(in_line)) |-> $stable(snap_bcd));

  // R4
  bcd_digit_chk: assert property (@(posedge clk) disable iff (rst)
    in_line |-> digits_ok(snap_bcd));
endmodule

bind freq_report fc_report_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .BCD_W(BCD_W), .MAX_VAL(10**NDIG - 1)
) chk_i (
  .clk(clk), .rst(rst), .uart_tx(uart_tx), .tx_busy(tx_busy),
  .in_line(in_line), .snap_bcd(snap_bcd), .chan_sel(chan_sel),
  .line_done(line_done), .conv_start(conv_start), .snap_cnt(snap_cnt)
);

// File: tb/freq_report_tb_top.sv
`timescale 1ns/1ps
module freq_report_tb_top;
  localparam int NCH  = 4;
  localparam int GATE = 1000;
  localparam int DIV  = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] mclk = '0;
  logic           tx0, tx1;
  bit             stop1 = 1'b0;
  bit             rx_on = 1'b0;
  bit             done  = 1'b0;
  int             checks = 0;
  int             failures = 0;
  string          q0[$];
  string          q1[$];
  int             counts[NCH] = '{500, 250, 125, 200};

  always #2.5 clk = ~clk;

  initial begin #1.3; forever #5    mclk[0] = ~mclk[0]; end
  initial begin #1.3; forever begin #10; if (!stop1) mclk[1] = ~mclk[1]; end end
  initial begin #1.3; forever #20   mclk[2] = ~mclk[2]; end
  initial begin #1.3; forever #12.5 mclk[3] = ~mclk[3]; end

  freq_report #(.NCH(NCH), .GATE_CYCLES(GATE), .BAUD_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .meas_clk(mclk), .uart_tx(tx0));

  freq_report #(.NCH(NCH), .GATE_CYCLES(GATE), .BAUD_DIV(DIV),
                .INT_DIGITS(1), .FRAC_DIGITS(1)) dut_sat (
    .clk(clk), .rst(rst), .meas_clk(mclk), .uart_tx(tx1));

  task automatic check(input string req, input logic ok, input string got, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: got %s expected %s", req, got, exp);
    end
  endtask

  function automatic logic get_tx(input int w);
    return (w == 0) ? tx0 : tx1;
  endfunction

  // R1 reset state, compared on every clock while reset is held
  always @(negedge clk)
    if (rst) check("R1", tx0 === 1'b1 && tx1 === 1'b1,
                   $sformatf("%b/%b", tx0, tx1), "1/1");

  task automatic rx_char(input int w, output byte c);
    c = 8'h00;
    do @(negedge clk); while (get_tx(w) != 1'b0);
    repeat (DIV / 2) @(negedge clk);
    if (get_tx(w) != 1'b0) check("R1", 1'b0, "start bit high", "start bit low");
    for (int b = 0; b < 8; b++) begin
      repeat (DIV) @(negedge clk);
      c[b] = get_tx(w);
    end
    repeat (DIV) @(negedge clk);
    if (get_tx(w) != 1'b1) check("R1", 1'b0, "stop bit low", "stop bit high");
  endtask

  task automatic rx_line(input int w, output string s);
    byte c;
    s = "";
    do begin
      rx_char(w, c);
      s = $sformatf("%s%c", s, c);
    end while (c != 8'h0A);
  endtask

  initial begin
    string s;
    wait (rx_on);
    forever begin rx_line(0, s); q0.push_back(s); end
  end

  initial begin
    string s;
    wait (rx_on);
    forever begin rx_line(1, s); q1.push_back(s); end
  end

  function automatic string exp_line(input int ch, input int v, input int idig, input int fdig);
    int nd;
    int lim;
    string num;
    nd  = idig + fdig;
    lim = 10**nd - 1;
    num = "";
    if (v > lim) v = lim;
    for (int k = nd - 1; k >= 0; k--) begin
      num = $sformatf("%s%0d", num, (v / (10**k)) % 10);
      if (k == fdig) num = {num, "."};
    end
    return $sformatf("Channel %0d:  %s MHz%c%c", ch, num, 8'd13, 8'd10);
  endfunction

  task automatic pop_line(input int w, output string s);
    if (w == 0) begin
      while (q0.size() == 0) @(negedge clk);
      s = q0.pop_front();
    end else begin
      while (q1.size() == 0) @(negedge clk);
      s = q1.pop_front();
    end
  endtask

  // take n fresh lines from one instance and compare with the model
  task automatic take(input int w, input int n, input int dead_ch, input string tag);
    string s;
    int first;
    int ch;
    int v;
    first = 0;
    if (w == 0) q0.delete(); else q1.delete();
    pop_line(w, s);
    for (int i = 0; i < n; i++) begin
      pop_line(w, s);
      ch = (s.len() > 8) ? int'(s[8]) - 48 : -1;
      if (i == 0) first = ch;
      check("R3", ch == (first + i) % NCH && ch >= 0 && ch < NCH,
            $sformatf("channel %0d", ch), $sformatf("channel %0d", (first + i) % NCH));
      if (ch < 0 || ch >= NCH) ch = 0;
      v = (ch == dead_ch) ? 0 : counts[ch];
      check(tag, s == exp_line(ch, v, w == 0 ? 3 : 1, w == 0 ? 5 : 1), s,
            exp_line(ch, v, w == 0 ? 3 : 1, w == 0 ? 5 : 1));
    end
  endtask

  initial begin
    repeat (10) @(posedge clk);
    rst <= 1'b0;
    rx_on = 1'b1;
    repeat (4 * GATE) @(posedge clk);
    // R2 R4 steady readings on four distinct rates
    take(0, 8, -1, "R2,R4");
    // R6 two-digit instance clamps every channel
    take(1, 4, -1, "R6");
    // R5 channel 1 clock stopped, others unaffected
    stop1 = 1'b1;
    repeat (4 * GATE) @(posedge clk);
    take(0, 8, 1, "R5");
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule